// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is one DMA channel that works through a chain of descriptors held in memory. It moves bytes between a 32-bit word-wide memory port and a byte-wide device stream, in either direction. Software stores descriptors in memory and writes the address of the first one into the pointer register. It then starts the channel through the control register. The engine reads the three words of each descriptor and moves that buffer one memory word at a time. It then rewrites the descriptor's count/info word with a completion bit, and either follows the link to the next descriptor or stops when the descriptor marks the end of the chain.

Each descriptor is three consecutive words: the buffer address (word aligned), the count/info word, and the address of the next descriptor. The count/info word carries the byte count in bits 13:0, a stop flag in bit 31, a packet-end flag in bit 30 and an interrupt request in bit 29. On transmit the engine reads memory words and hands their bytes to the device one at a time. On receive it packs incoming bytes into words and writes those words to memory. Register select 0 is the next-descriptor pointer. Register select 1 is control and status.

Top module: `dma_chain_engine`

## Requirements
- R1: Writing 1 to control bit 0 while the channel is idle starts it. The engine reads the descriptor words at P, P+4 and P+8, where P is the value in the pointer register. After that fetch, the pointer register holds the link word of the descriptor just read.
- R2: The byte count is bits 13:0 of the count/info word, and exactly that many bytes move. A count of zero moves no data, but the descriptor is still written back.
- R3: With control bit 1 clear, the bytes of each memory word travel most significant first (bits 31:24 first). With bit 1 set, they travel least significant first (bits 7:0 first). The same byte-lane order applies in both directions.
- R4: `tx_last` is high with the final byte of a transmit buffer only when bit 30 of its count/info word is set. It is never high with any other byte.
- R5: When bit 31 of the count/info word is set, the channel goes inactive (status bit 0 low) after the writeback and does not follow the link. When bit 31 is clear, the engine continues with the descriptor at the link address.
- R6: After a buffer completes, the engine writes the count/info word back to descriptor address +4 with its other bits unchanged. It sets bit 15 on transmit and bit 14 on receive.
- R7: Control bit 2 selects receive. In receive mode, bytes are packed into words in lane order and written to consecutive addresses from the buffer address upward. The unused lanes of a final partial word are zero, and no word beyond the buffer is written.
- R8: Bit 29 of the count/info word sets the interrupt flag (status bit 4 and `irq`) when that descriptor's writeback is granted. The flag holds until software writes 1 to control bit 4. If the clear and a new set land in the same cycle, the flag stays set.
- R9: Status bit 5 goes high once the engine has read a count/info word with bit 31 set, meaning it is too late to append a descriptor. A start clears it.
- R10: Writing 1 to control bit 3 resets the channel. From the next cycle the channel is inactive with no memory request, the interrupt and status bit 5 are cleared, and `dev_rst` pulses high for exactly one cycle.
- R11: A memory request is held, with unchanged address, write enable and write data, until `mem_gnt` is seen (unless a channel reset occurs).
- R12: While the channel is active, writes to the pointer register and to the mode bits (control bits 1 and 2) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = pointer register, 1 = control/status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_gnt` |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Byte ends a packet |
| tx_ready | input | 1 | Device takes the transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Engine takes the receive byte |
| irq | output | 1 | Interrupt flag |
| dev_rst | output | 1 | One-cycle reset pulse to the device |

## Verification
The bench sweeps the byte count from 0 to 9 in both lane orders and both directions. This covers partial final words, and an off-by-one in the word/byte counters would show up there as a lost byte, an extra memory word or a misplaced `tx_last`. A three-descriptor chain shows whether the engine follows links, keeps the packet-end mark to its own buffers, ignores register writes made mid-run, and stops at the end marker rather than walking on. A clear timed to land on the cycle of a granted writeback catches a flag that gives the clear priority. A channel reset during a receive catches an engine that keeps requesting memory or leaves stale status behind. Grants arrive with stalls throughout, so a request that drifts while waiting would be counted.

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter int CW = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        irq,
  output logic        dev_rst
);
  localparam int STOP_B = 31;
  localparam int PEND_B = 30;
  localparam int INT_B  = 29;
  localparam logic [31:0] TX_DONE = 32'h0000_8000;
  localparam logic [31:0] RX_OWN  = 32'h0000_4000;

  typedef enum logic [3:0] {
    S_IDLE, S_PTR, S_CNT, S_NXT, S_RD, S_TX, S_RX, S_WR, S_WB
  } st_t;

  st_t st;
  logic [31:0] nxt, dsc, bptr, info, wbuf;
  logic [CW-1:0] cnt;
  logic [1:0] bidx;
  logic act, swp, dir, irq_q, late, drst;

  wire ctl_wr   = reg_wr && reg_sel;
  wire chan_rst = ctl_wr && reg_wdata[3];
  wire go       = ctl_wr && reg_wdata[0] && !act && !chan_rst;
  wire [1:0] lane = swp ? bidx : ~bidx;
  wire last_byte = (cnt == CW'(1));
  wire irq_set  = (st == S_WB) && mem_gnt && info[INT_B];

  assign mem_req  = (st == S_PTR) || (st == S_CNT) || (st == S_NXT) ||
                    (st == S_RD)  || (st == S_WR)  || (st == S_WB);
  assign mem_we   = (st == S_WR) || (st == S_WB);
  assign mem_wdata = (st == S_WB) ? (info | (dir ? RX_OWN : TX_DONE)) : wbuf;

  always_comb begin
    case (st)
      S_PTR:       mem_addr = dsc;
      S_CNT, S_WB: mem_addr = dsc + 32'd4;
      S_NXT:       mem_addr = dsc + 32'd8;
      default:     mem_addr = bptr;
    endcase
  end

  assign tx_valid = (st == S_TX);
  assign tx_data  = wbuf[{lane, 3'b000} +: 8];
  assign tx_last  = tx_valid && info[PEND_B] && last_byte;
  assign rx_ready = (st == S_RX);
  assign reg_rdata = reg_sel ? {26'd0, late, irq_q, 1'b0, dir, swp, act} : nxt;
  assign irq     = irq_q;
  assign dev_rst = drst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      nxt <= '0; dsc <= '0; bptr <= '0; info <= '0; wbuf <= '0;
      cnt <= '0; bidx <= '0;
      act <= 1'b0; swp <= 1'b0; dir <= 1'b0;
      irq_q <= 1'b0; late <= 1'b0; drst <= 1'b0;
    end else begin
      drst <= chan_rst;
      if (chan_rst)                     irq_q <= 1'b0;
      else if (irq_set)                 irq_q <= 1'b1;
      else if (ctl_wr && reg_wdata[4])  irq_q <= 1'b0;

      if (chan_rst) begin
        st <= S_IDLE;
        act <= 1'b0;
        late <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            if (reg_wr && !reg_sel) nxt <= reg_wdata;
            if (ctl_wr) begin
              swp <= reg_wdata[1];
              dir <= reg_wdata[2];
            end
            if (go) begin
              act  <= 1'b1;
              late <= 1'b0;
              dsc  <= nxt;
              st   <= S_PTR;
            end
          end
          S_PTR: if (mem_gnt) begin
            bptr <= mem_rdata;
            st   <= S_CNT;
          end
          S_CNT: if (mem_gnt) begin
            info <= mem_rdata;
            cnt  <= mem_rdata[CW-1:0];
            late <= mem_rdata[STOP_B];
            st   <= S_NXT;
          end
          S_NXT: if (mem_gnt) begin
            nxt  <= mem_rdata;
            bidx <= '0;
            wbuf <= '0;
            if (cnt == '0) st <= S_WB;
            else           st <= dir ? S_RX : S_RD;
          end
          S_RD: if (mem_gnt) begin
            wbuf <= mem_rdata;
            bptr <= bptr + 32'd4;
            bidx <= '0;
            st   <= S_TX;
          end
          S_TX: if (tx_ready) begin
            cnt  <= cnt - CW'(1);
            bidx <= bidx + 2'd1;
            if (last_byte)          st <= S_WB;
            else if (bidx == 2'd3)  st <= S_RD;
          end
          S_RX: if (rx_valid) begin
            wbuf[{lane, 3'b000} +: 8] <= rx_data;
            cnt  <= cnt - CW'(1);
            bidx <= bidx + 2'd1;
            if (last_byte || bidx == 2'd3) st <= S_WR;
          end
          S_WR: if (mem_gnt) begin
            bptr <= bptr + 32'd4;
            wbuf <= '0;
            bidx <= '0;
            st   <= (cnt == '0) ? S_WB : S_RX;
          end
          S_WB: if (mem_gnt) begin
            if (info[STOP_B]) begin
              act <= 1'b0;
              st  <= S_IDLE;
            end else begin
              dsc <= nxt;
              st  <= S_PTR;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_chain_engine_chk.sv
module dma_chain_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_reset,
  input logic        act,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_gnt,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        tx_valid,
  input logic        tx_last,
  input logic        rx_ready,
  input logic        irq,
  input logic        dev_rst
);
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n || ctl_reset)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r10_chan_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> !act && !mem_req && dev_rst);

  a_r4_last_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  a_r8_irq_from_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mem_req && mem_we && mem_gnt));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !mem_req && !tx_valid && !rx_ready);

  a_r3_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));
endmodule

bind dma_chain_engine dma_chain_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_reset(reg_wr && reg_sel && reg_wdata[3]),
  .act(act), .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tx_valid(tx_valid),
  .tx_last(tx_last), .rx_ready(rx_ready), .irq(irq), .dev_rst(dev_rst)
);

// File: tb/dma_chain_engine_test.sv
module dma_chain_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic tx_valid, tx_last, tx_ready, rx_valid, rx_ready, irq, dev_rst;
  logic [7:0] tx_data, rx_data;

  dma_chain_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .irq(irq), .dev_rst(dev_rst)
  );

  logic [31:0] mem [0:255];
  logic [1:0] gcnt = '0;
  logic [2:0] tcnt = '0;
  logic [7:0] rxseq = 8'h30;
  logic [7:0] txb [0:63];
  logic txl [0:63];
  int txn = 0;
  logic tx_clr = 1'b0;
  logic pend = 1'b0, pw = 1'b0;
  logic [31:0] pa = '0, pd = '0;
  int r11_bad = 0;
  int total = 0, fails = 0;

  assign mem_gnt   = mem_req && (gcnt != 2'd0);
  assign mem_rdata = mem[mem_addr[9:2]];
  assign tx_ready  = (tcnt != 3'd5);
  assign rx_valid  = (tcnt != 3'd2);
  assign rx_data   = rxseq;

  always @(posedge clk) begin
    gcnt <= gcnt + 2'd1;
    tcnt <= tcnt + 3'd1;
    if (mem_req && mem_we && mem_gnt) mem[mem_addr[9:2]] <= mem_wdata;
    if (rx_valid && rx_ready) rxseq <= rxseq + 8'd13;
    if (tx_clr) txn <= 0;
    else if (tx_valid && tx_ready && txn < 64) begin
      txb[txn] <= tx_data;
      txl[txn] <= tx_last;
      txn <= txn + 1;
    end
    if (rst_n && pend && (!mem_req || mem_addr != pa || mem_we != pw || mem_wdata != pd))
      r11_bad <= r11_bad + 1;
    pend <= rst_n && mem_req && !mem_gnt && !(reg_wr && reg_sel && reg_wdata[3]);
    pa <= mem_addr; pw <= mem_we; pd <= mem_wdata;
  end

  function automatic logic [31:0] pat(int i);
    return 32'h1122_3344 ^ (32'(i) * 32'h0103_0507);
  endfunction

  function automatic logic [7:0] bexp(int base, int k, bit sw);
    logic [31:0] w;
    int ln;
    w  = pat(base + (k >> 2));
    ln = sw ? (k & 3) : 3 - (k & 3);
    return w[ln*8 +: 8];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act_v, logic [31:0] exp_v);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act_v, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic reg_write(logic s, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic s, output logic [31:0] v);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic clear_tx();
    @(negedge clk); tx_clr = 1'b1;
    @(negedge clk); tx_clr = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    logic [31:0] v;
    do begin
      @(negedge clk);
      reg_read(1'b1, v);
      n++;
    end while (v[0] && n < 20000);
    if (n >= 20000) check(1'b0, "R5 timeout", v, 32'd0);
  endtask

  task automatic put_desc(int widx, logic [31:0] b, logic [31:0] inf, logic [31:0] nx);
    mem[widx] = b; mem[widx+1] = inf; mem[widx+2] = nx;
  endtask

  task automatic run_tx(bit sw, int len);
    logic [31:0] inf, v;
    int bad3 = 0, bad4 = 0;
    inf = 32'hE000_0000 | 32'(len);
    put_desc(8'h10, 32'h80, inf, 32'h370);
    for (int j = 0; j < 4; j++) mem[8'h20 + j] = pat(j);
    clear_tx();
    reg_write(1'b0, 32'h40);
    reg_write(1'b1, 32'h10 | (32'(sw) << 1));
    reg_write(1'b1, 32'h1 | (32'(sw) << 1));
    wait_idle();
    check(txn == len, "R2 byte count", 32'(txn), 32'(len));
    for (int k = 0; k < len; k++) begin
      if (txb[k] != bexp(0, k, sw)) bad3++;
      if (txl[k] != (k == len - 1)) bad4++;
    end
    check(bad3 == 0, "R3 lane order", 32'(bad3), 32'd0);
    check(bad4 == 0, "R4 last flag", 32'(bad4), 32'd0);
    check(mem[8'h11] == (inf | 32'h8000), "R6 tx writeback", mem[8'h11], inf | 32'h8000);
    reg_read(1'b1, v);
    check(v[4] && v[5] && !v[0], "R8 R9 R5 status", v, 32'h30 | (32'(sw) << 1));
    reg_read(1'b0, v);
    check(v == 32'h370, "R1 link loaded", v, 32'h370);
  endtask

  task automatic run_rx(bit sw, int len);
    logic [31:0] inf, e;
    logic [7:0] base;
    int bad = 0;
    inf = 32'hA000_0000 | 32'(len);
    put_desc(8'h10, 32'h80, inf, 32'h0);
    for (int j = 0; j < 4; j++) mem[8'h20 + j] = 32'hDEAD_BEEF;
    clear_tx();
    base = rxseq;
    reg_write(1'b0, 32'h40);
    reg_write(1'b1, 32'h14 | (32'(sw) << 1));
    reg_write(1'b1, 32'h5 | (32'(sw) << 1));
    wait_idle();
    for (int w = 0; w < 4; w++) begin
      if (w * 4 >= len) e = 32'hDEAD_BEEF;
      else begin
        e = '0;
        for (int b = 0; b < 4; b++) begin
          int k = w * 4 + b;
          int ln = sw ? b : 3 - b;
          if (k < len) e[ln*8 +: 8] = base + 8'(13 * k);
        end
      end
      if (mem[8'h20 + w] != e) begin
        bad++;
        $display("FAIL R7 rx word %0d: actual %h expected %h", w, mem[8'h20 + w], e);
      end
    end
    total++;
    if (bad != 0) fails++;
    check(mem[8'h11] == (inf | 32'h4000), "R6 rx writeback", mem[8'h11], inf | 32'h4000);
    check(txn == 0, "R7 no tx bytes", 32'(txn), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int bad;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(1'b1, v);
    check(v == 0 && !irq && !mem_req && !dev_rst, "R10 reset state", v, 32'd0);
    reg_read(1'b0, v);
    check(v == 0, "R1 pointer reset", v, 32'd0);

    for (int s = 0; s < 2; s++)
      for (int n = 0; n < 10; n++) run_tx(s[0], n);
    for (int s = 0; s < 2; s++)
      for (int n = 0; n < 10; n++) run_rx(s[0], n);

    // R5 R12 three-descriptor chain
    put_desc(8'h10, 32'h100, 32'h2000_0005, 32'h60);
    put_desc(8'h18, 32'h140, 32'h4000_0003, 32'hA0);
    put_desc(8'h28, 32'h180, 32'hC000_0006, 32'h2C0);
    for (int j = 0; j < 4; j++) begin
      mem[8'h40 + j] = pat(100 + j);
      mem[8'h50 + j] = pat(200 + j);
      mem[8'h60 + j] = pat(300 + j);
    end
    clear_tx();
    reg_write(1'b0, 32'h40);
    reg_write(1'b1, 32'h10);
    reg_write(1'b1, 32'h1);
    reg_read(1'b1, v);
    check(!v[5] && v[0], "R9 flag cleared by start", v, 32'h1);
    reg_write(1'b0, 32'h3F0);
    reg_write(1'b1, 32'h6);
    wait_idle();
    check(txn == 14, "R5 chain byte total", 32'(txn), 32'd14);
    bad = 0;
    for (int k = 0; k < 14; k++) begin
      logic [7:0] e;
      if (k < 5)      e = bexp(100, k, 1'b0);
      else if (k < 8) e = bexp(200, k - 5, 1'b0);
      else            e = bexp(300, k - 8, 1'b0);
      if (txb[k] != e) bad++;
    end
    check(bad == 0, "R3 chain bytes", 32'(bad), 32'd0);
    bad = 0;
    for (int k = 0; k < 14; k++) if (txl[k] != (k == 7 || k == 13)) bad++;
    check(bad == 0, "R4 chain last flags", 32'(bad), 32'd0);
    check(mem[8'h11] == 32'h2000_8005, "R6 chain wb0", mem[8'h11], 32'h2000_8005);
    check(mem[8'h19] == 32'h4000_8003, "R6 chain wb1", mem[8'h19], 32'h4000_8003);
    check(mem[8'h29] == 32'hC000_8006, "R6 chain wb2", mem[8'h29], 32'hC000_8006);
    reg_read(1'b0, v);
    check(v == 32'h2C0, "R12 pointer write ignored", v, 32'h2C0);
    repeat (20) @(negedge clk);
    reg_read(1'b1, v);
    check(v == 32'h30, "R12 R8 mode kept, irq held", v, 32'h30);
    reg_write(1'b1, 32'h10);
    check(!irq, "R8 clear", 32'(irq), 32'd0);

    // R8 clear colliding with a new set
    put_desc(8'h10, 32'h80, 32'hA000_0001, 32'h0);
    clear_tx();
    reg_write(1'b0, 32'h40);
    reg_write(1'b1, 32'h1);
    bad = 0;
    while (!(mem_req && mem_we && mem_gnt && mem_addr == 32'h44) && bad < 2000) begin
      @(negedge clk);
      bad++;
    end
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h10;
    @(negedge clk);
    reg_wr = 1'b0;
    check(irq, "R8 set wins over clear", 32'(irq), 32'd1);
    wait_idle();
    reg_write(1'b1, 32'h10);
    check(!irq, "R8 later clear", 32'(irq), 32'd0);

    // R10 channel reset during a receive
    put_desc(8'h10, 32'h80, 32'h2000_0009, 32'h0);
    reg_write(1'b0, 32'h40);
    reg_write(1'b1, 32'h5);
    repeat (8) @(negedge clk);
    reg_write(1'b1, 32'h8);
    reg_read(1'b1, v);
    check(dev_rst && !mem_req && !rx_ready, "R10 abort", {29'd0, dev_rst, mem_req, rx_ready}, 32'h4);
    check(v[0] == 1'b0 && v[5:4] == 2'b00, "R10 status cleared", v, 32'h4);
    @(negedge clk);
    check(!dev_rst, "R10 pulse width", 32'(dev_rst), 32'd0);
    run_tx(1'b0, 4);

    check(r11_bad == 0, "R11 request held", 32'(r11_bad), 32'd0);
    finish_run();
  end
endmodule